// File: doc/BRIEF.md
# Multimode complex CORDIC rotation array

This block rotates a pair of four-element complex vectors every clock with a pipeline of shift-and-add micro-rotations. Element 0 of the pair steers the rotation. A vectoring step drives that element towards a nulled form and produces one direction bit per iteration. In the same stage, those bits are sent to every element, so all four element pairs turn through the same angle. Rotation stages therefore hold no angle tables and no phase decoding of their own.

A two-bit mode sets how the real and imaginary rails are routed into the shift-and-add pairs. In mode 0 the block applies a complex Givens rotation. It first removes the phase of the leading second-vector element, then rotates the two vectors against each other until that element is zero. In mode 1 it applies two separate real rotations: one acts on the real rails and the other on the imaginary rails, each with its own angle. In mode 2 it applies one real angle to both rail pairs, which is the step needed for Jacobi-style diagonalisation. When the external-phase input is set, the vectoring decision is bypassed. The supplied direction words then rotate all four elements, element 0 included.

The outputs carry the accumulated CORDIC gain and are not scaled back. The vectoring paths expect their leading rail to be non-negative. In mode 0 that means the leading first-vector element is real and non-negative and the leading second-vector element has a non-negative real part. In modes 1 and 2 it means the leading first-vector element is real and non-negative.

Top module: `cordic_pair_rotator`

## Requirements
- R1: While reset is held, and until the first accepted input has crossed the pipeline, `out_valid` stays low.
- R2: Each input accepted with `in_valid` high comes out exactly 2*N = 24 clocks later with `out_valid` high. A new input can be accepted on every clock. No output appears without a matching input.
- R3: Mode 0 with vectoring: output element 0 of vector b is zero on both rails. Element 0 of vector a is real and non-negative.
- R4: Mode 0: every element of b is first rotated by minus the phase of input b[0]. Then each element is rotated in the (a, b) plane, on the real rails and on the imaginary rails alike, by the angle that nulls the real part of the rotated b[0] against a[0].
- R5: Mode 1: the pairs (a.re, b.re) are rotated by the angle that nulls b[0].re against a[0].re. The pairs (a.im, b.im) are rotated by an independent angle that nulls b[0].im against a[0].im.
- R6: Mode 2, and the reserved code 3 which behaves the same: both rail pairs of every element are rotated by the single angle that nulls b[0].re against a[0].re.
- R7: With `in_ext` high, bit i of a direction word selects a counter-clockwise micro-rotation of atan(2^-i) when 1 and a clockwise one when 0. `in_dir_a` drives the phase step of mode 0. `in_dir_b1` drives the plane step of all modes. `in_dir_b2` drives the imaginary-rail pair only in mode 1. All four elements are rotated, and each unused word has no effect.
- R8: Gain is not compensated. Each active rotation step multiplies magnitudes by K = prod(sqrt(1+2^-2i)) over i = 0..N-1. In mode 0, b therefore carries K^2 and a carries K.
- R9: Inputs in different modes and with different phase sources, sent on consecutive clocks, each come out as if sent alone.
- R10: Input element k sits at bits [k*16 +: 16] of each input rail bus. Output element k sits at bits [k*19 +: 19], as a signed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the valid pipeline |
| in_valid | input | 1 | Input pair present this clock |
| in_mode | input | 2 | 0 complex Givens, 1 two real rotations, 2/3 single-phase |
| in_ext | input | 1 | Use supplied direction words instead of vectoring |
| in_dir_a | input | 12 | Phase-step direction bits (mode 0, external) |
| in_dir_b1 | input | 12 | Plane-step direction bits (external) |
| in_dir_b2 | input | 12 | Imaginary-rail direction bits (mode 1, external) |
| in_a_re | input | 64 | Vector a real rails, four signed 16-bit elements |
| in_a_im | input | 64 | Vector a imaginary rails |
| in_b_re | input | 64 | Vector b real rails |
| in_b_im | input | 64 | Vector b imaginary rails |
| out_valid | output | 1 | Output pair present |
| out_a_re | output | 76 | Rotated a real rails, four signed 19-bit elements |
| out_a_im | output | 76 | Rotated a imaginary rails |
| out_b_re | output | 76 | Rotated b real rails |
| out_b_im | output | 76 | Rotated b imaginary rails |

## Verification
Every result is due 24 clocks after the falling edge on which its input was driven: 12 phase-step stages followed by 12 plane-step stages, with one register each. The driver records the cycle count when it pushes the expected rails into the scoreboard. The monitor reads outputs on falling edges only and checks that exactly 24 cycles have passed, so a stage that is added or missing is caught even when the values are right. Expected rails come from a real-valued rotation model that applies the same uncompensated gain, and each rail is compared within a small tolerance that covers truncation and the final residual angle.

// File: rtl/cordic_pair_rotator.sv
module cordic_pair_rotator #(
  parameter int W = 16,
  parameter int N = 12,
  parameter int G = 3,
  parameter int E = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_mode,
  input  logic              in_ext,
  input  logic [N-1:0]      in_dir_a,
  input  logic [N-1:0]      in_dir_b1,
  input  logic [N-1:0]      in_dir_b2,
  input  logic [E*W-1:0]    in_a_re,
  input  logic [E*W-1:0]    in_a_im,
  input  logic [E*W-1:0]    in_b_re,
  input  logic [E*W-1:0]    in_b_im,
  output logic              out_valid,
  output logic [E*(W+G)-1:0] out_a_re,
  output logic [E*(W+G)-1:0] out_a_im,
  output logic [E*(W+G)-1:0] out_b_re,
  output logic [E*(W+G)-1:0] out_b_im
);
  localparam int OW = W + G;
  localparam int S  = 2 * N;
  localparam int CW = $clog2(S + 1);

  logic signed [OW-1:0] i_ar [S][E], i_ai [S][E], i_br [S][E], i_bi [S][E];
  logic signed [OW-1:0] n_ar [S][E], n_ai [S][E], n_br [S][E], n_bi [S][E];
  logic signed [OW-1:0] r_ar [S][E], r_ai [S][E], r_br [S][E], r_bi [S][E];
  logic [1:0]   i_md [S], r_md [S];
  logic         i_ex [S], r_ex [S];
  logic [N-1:0] i_da [S], i_d1 [S], i_d2 [S];
  logic [N-1:0] r_da [S-1], r_d1 [S-1], r_d2 [S-1];
  logic         dir1 [S], dir2 [S];
  logic [S-1:0] i_v, r_v;

  function automatic logic signed [OW-1:0] sx(input logic [W-1:0] x);
    return {{G{x[W-1]}}, x};
  endfunction

  function automatic logic [2*OW-1:0] mrot(input logic signed [OW-1:0] x,
                                           input logic signed [OW-1:0] y,
                                           input logic d, input int sh);
    logic signed [OW-1:0] xs, ys;
    xs = x >>> sh;
    ys = y >>> sh;
    return d ? {x - ys, y + xs} : {x + ys, y - xs};
  endfunction

  assign i_v = {r_v[S-2:0], in_valid};

  always_comb begin
    for (int s = 0; s < S; s++) begin
      if (s == 0) begin
        i_md[s] = in_mode;  i_ex[s] = in_ext;
        i_da[s] = in_dir_a; i_d1[s] = in_dir_b1; i_d2[s] = in_dir_b2;
        for (int k = 0; k < E; k++) begin
          i_ar[s][k] = sx(in_a_re[k*W +: W]);
          i_ai[s][k] = sx(in_a_im[k*W +: W]);
          i_br[s][k] = sx(in_b_re[k*W +: W]);
          i_bi[s][k] = sx(in_b_im[k*W +: W]);
        end
      end else begin
        i_md[s] = r_md[s-1]; i_ex[s] = r_ex[s-1];
        i_da[s] = r_da[s-1]; i_d1[s] = r_d1[s-1]; i_d2[s] = r_d2[s-1];
        for (int k = 0; k < E; k++) begin
          i_ar[s][k] = r_ar[s-1][k];
          i_ai[s][k] = r_ai[s-1][k];
          i_br[s][k] = r_br[s-1][k];
          i_bi[s][k] = r_bi[s-1][k];
        end
      end

      if (s < N) begin
        // phase step: remove the angle of b[0] from every b element (mode 0 only)
        dir1[s] = i_ex[s] ? i_da[s][s % N] : i_bi[s][0][OW-1];
        dir2[s] = 1'b0;
        for (int k = 0; k < E; k++) begin
          n_ar[s][k] = i_ar[s][k];
          n_ai[s][k] = i_ai[s][k];
          if (i_md[s] == 2'd0)
            {n_br[s][k], n_bi[s][k]} = mrot(i_br[s][k], i_bi[s][k], dir1[s], s % N);
          else begin
            n_br[s][k] = i_br[s][k];
            n_bi[s][k] = i_bi[s][k];
          end
        end
      end else begin
        // plane step: real-rail pair and imaginary-rail pair
        dir1[s] = i_ex[s] ? i_d1[s][s % N] : i_br[s][0][OW-1];
        dir2[s] = (i_md[s] == 2'd1) ? (i_ex[s] ? i_d2[s][s % N] : i_bi[s][0][OW-1])
                                    : dir1[s];
        for (int k = 0; k < E; k++) begin
          {n_ar[s][k], n_br[s][k]} = mrot(i_ar[s][k], i_br[s][k], dir1[s], s % N);
          {n_ai[s][k], n_bi[s][k]} = mrot(i_ai[s][k], i_bi[s][k], dir2[s], s % N);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    r_ar <= n_ar; r_ai <= n_ai; r_br <= n_br; r_bi <= n_bi;
    r_md <= i_md; r_ex <= i_ex;
    for (int s = 0; s < S - 1; s++) begin
      r_da[s] <= i_da[s];
      r_d1[s] <= i_d1[s];
      r_d2[s] <= i_d2[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_v <= '0;
    else        r_v <= i_v;
  end

  assign out_valid = r_v[S-1];

  for (genvar k = 0; k < E; k++) begin : g_out
    assign out_a_re[k*OW +: OW] = r_ar[S-1][k];
    assign out_a_im[k*OW +: OW] = r_ai[S-1][k];
    assign out_b_re[k*OW +: OW] = r_br[S-1][k];
    assign out_b_im[k*OW +: OW] = r_bi[S-1][k];
  end

  logic [CW-1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != CW'(S)) since_rst <= since_rst + 1'b1;
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < CW'(S)) |-> !out_valid);

  assert_phase_null_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (r_v[N-1] && r_md[N-1] == 2'd0 && !r_ex[N-1]) |->
    (r_bi[N-1][0] < 64 && r_bi[N-1][0] > -64));

  assert_givens_null_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && r_md[S-1] == 2'd0 && !r_ex[S-1]) |->
    (r_br[S-1][0] < 256 && r_br[S-1][0] > -256 && r_ar[S-1][0] >= 0));

  assert_dual_null_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && r_md[S-1] == 2'd1 && !r_ex[S-1]) |->
    (r_br[S-1][0] < 256 && r_br[S-1][0] > -256 &&
     r_bi[S-1][0] < 256 && r_bi[S-1][0] > -256));

  assert_single_null_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && r_md[S-1][1] && !r_ex[S-1]) |->
    (r_br[S-1][0] < 256 && r_br[S-1][0] > -256));
endmodule

// File: tb/cordic_pair_rotator_tb.sv
`timescale 1ns/1ps
module cordic_pair_rotator_tb;
  localparam int W = 16, N = 12, G = 3, E = 4;
  localparam int OW = W + G, S = 2 * N;
  localparam real TOL = 40.0;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_ext = 1'b0;
  logic [1:0] in_mode = '0;
  logic [N-1:0] in_dir_a = '0, in_dir_b1 = '0, in_dir_b2 = '0;
  logic [E*W-1:0] in_a_re = '0, in_a_im = '0, in_b_re = '0, in_b_im = '0;
  logic out_valid;
  logic [E*OW-1:0] out_a_re, out_a_im, out_b_re, out_b_im;

  always #4 clk = ~clk;

  cordic_pair_rotator u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode), .in_ext(in_ext),
    .in_dir_a(in_dir_a), .in_dir_b1(in_dir_b1), .in_dir_b2(in_dir_b2),
    .in_a_re(in_a_re), .in_a_im(in_a_im), .in_b_re(in_b_re), .in_b_im(in_b_im),
    .out_valid(out_valid), .out_a_re(out_a_re), .out_a_im(out_a_im),
    .out_b_re(out_b_re), .out_b_im(out_b_im));

  int cyc = 0, n_chk = 0, n_fail = 0, seed = 12345;
  bit finished = 0;
  real kk = 1.0;
  real exq[$];
  int tq[$];
  string tagq[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic real dirang(input logic [N-1:0] d);
    real a = 0.0;
    for (int i = 0; i < N; i++) a += (d[i] ? 1.0 : -1.0) * $atan(1.0 / (2.0 ** i));
    return a;
  endfunction

  task automatic rotp(inout real x, inout real y, input real phi);
    real t;
    t = kk * (x * $cos(phi) - y * $sin(phi));
    y = kk * (x * $sin(phi) + y * $cos(phi));
    x = t;
  endtask

  function automatic int rnd(input int lo, input int hi);
    seed = seed * 1103515245 + 12345;
    return lo + ((seed >>> 8) & 32'h7fff) % (hi - lo + 1);
  endfunction

  // R10: element k of each input bus at [k*W +: W]
  task automatic send(input logic [1:0] m, input logic e, input logic [N-1:0] da,
                      input logic [N-1:0] db1, input logic [N-1:0] db2,
                      input int xar[E], input int xai[E], input int xbr[E], input int xbi[E],
                      input string tag);
    real ar[E], ai[E], br[E], bi[E];
    real pa, pb, p2;
    for (int k = 0; k < E; k++) begin
      ar[k] = xar[k]; ai[k] = xai[k]; br[k] = xbr[k]; bi[k] = xbi[k];
    end
    if (m == 2'd0) begin
      pa = e ? dirang(da) : -$atan2(bi[0], br[0]);
      for (int k = 0; k < E; k++) rotp(br[k], bi[k], pa);
    end
    pb = e ? dirang(db1) : -$atan2(br[0], ar[0]);
    p2 = (m == 2'd1) ? (e ? dirang(db2) : -$atan2(bi[0], ai[0])) : pb;
    for (int k = 0; k < E; k++) begin
      rotp(ar[k], br[k], pb);
      rotp(ai[k], bi[k], p2);
      exq.push_back(ar[k]); exq.push_back(ai[k]);
      exq.push_back(br[k]); exq.push_back(bi[k]);
    end
    tq.push_back(cyc);
    tagq.push_back(tag);
    in_mode = m; in_ext = e; in_dir_a = da; in_dir_b1 = db1; in_dir_b2 = db2;
    for (int k = 0; k < E; k++) begin
      in_a_re[k*W +: W] = xar[k][W-1:0];
      in_a_im[k*W +: W] = xai[k][W-1:0];
      in_b_re[k*W +: W] = xbr[k][W-1:0];
      in_b_im[k*W +: W] = xbi[k][W-1:0];
    end
    in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // R10: output element k at [k*OW +: OW], signed
  function automatic int rail(input int k, input int r);
    case (r)
      0: return int'($signed(out_a_re[k*OW +: OW]));
      1: return int'($signed(out_a_im[k*OW +: OW]));
      2: return int'($signed(out_b_re[k*OW +: OW]));
      default: return int'($signed(out_b_im[k*OW +: OW]));
    endcase
  endfunction

  task automatic check_out();
    int t0, got, bk, bq, bg;
    real ex, be;
    bit bad;
    string tg;
    if (tagq.size() == 0) begin
      n_chk++; n_fail++;
      $display("FAIL R2 output without pending input: got out_valid=1 expected 0");
      return;
    end
    t0 = tq.pop_front();
    tg = tagq.pop_front();
    n_chk++;
    if (cyc - t0 != S) begin
      n_fail++;
      $display("FAIL R2 latency (%s): got %0d expected %0d", tg, cyc - t0, S);
    end
    n_chk++;
    bad = 0; bk = 0; bq = 0; bg = 0; be = 0.0;
    for (int k = 0; k < E; k++)
      for (int r = 0; r < 4; r++) begin
        ex = exq.pop_front();
        got = rail(k, r);
        if (!bad && (real'(got) - ex > TOL || ex - real'(got) > TOL)) begin
          bad = 1; bk = k; bq = r; bg = got; be = ex;
        end
      end
    if (bad) begin
      n_fail++;
      $display("FAIL %s element %0d rail %0d: got %0d expected %0.1f", tg, bk, bq, bg, be);
    end
  endtask

  always @(negedge clk) if (rst_n && out_valid) check_out();

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: got no completion expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int ar[E], ai[E], br[E], bi[E];
    logic [1:0] m;
    logic e;
    for (int i = 0; i < N; i++) kk = kk * $sqrt(1.0 + 2.0 ** (-2 * i));
    repeat (4) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 during reset: got out_valid=%b expected 0", out_valid);
    end
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle after reset: got out_valid=%b expected 0", out_valid);
    end

    send(2'd0, 1'b0, '0, '0, '0, '{2000, -1500, 700, -300}, '{0, 800, -1200, 2500},
         '{1200, 400, -2600, 900}, '{-1800, 2100, 300, -700}, "R3 R4 R8 mode0");
    send(2'd0, 1'b0, '0, '0, '0, '{500, 1000, -2000, 3000}, '{0, -500, 1500, 100},
         '{2500, -100, 200, -3000}, '{900, -2900, 1800, 50}, "R3 R4 mode0");
    send(2'd1, 1'b0, '0, '0, '0, '{2500, -700, 1300, -2000}, '{0, 1600, -900, 400},
         '{-1400, 2200, 600, -100}, '{1900, -300, -2500, 1200}, "R5 R8 mode1");
    send(2'd1, 1'b0, '0, '0, '0, '{2000, -1500, 700, -300}, '{0, 800, -1200, 2500},
         '{1200, 400, -2600, 900}, '{-1800, 2100, 300, -700}, "R5 mode1 neg");
    idle(3);
    send(2'd2, 1'b0, '0, '0, '0, '{2500, -700, 1300, -2000}, '{0, 1600, -900, 400},
         '{-1400, 2200, 600, -100}, '{1900, -300, -2500, 1200}, "R6 R8 mode2");
    send(2'd3, 1'b0, '0, '0, '0, '{500, 1000, -2000, 3000}, '{0, -500, 1500, 100},
         '{2500, -100, 200, -3000}, '{900, -2900, 1800, 50}, "R6 mode3");
    send(2'd0, 1'b1, 12'hA5C, 12'h3F0, 12'hFFF, '{2500, -700, 1300, -2000},
         '{0, 1600, -900, 400}, '{-1400, 2200, 600, -100}, '{1900, -300, -2500, 1200},
         "R7 R4 ext mode0");
    send(2'd1, 1'b1, 12'h7E1, 12'h0F3, 12'h9A1, '{2000, -1500, 700, -300},
         '{300, 800, -1200, 2500}, '{1200, 400, -2600, 900}, '{-1800, 2100, 300, -700},
         "R7 R5 ext mode1");
    send(2'd2, 1'b1, 12'h123, 12'h555, 12'h000, '{500, 1000, -2000, 3000},
         '{-200, -500, 1500, 100}, '{2500, -100, 200, -3000}, '{900, -2900, 1800, 50},
         "R7 R6 ext mode2");
    send(2'd2, 1'b1, 12'hFFF, 12'h000, 12'hFFF, '{1000, 0, -1000, 2000},
         '{0, 1000, 500, -2000}, '{0, 1500, -700, 300}, '{1200, -400, 900, 0},
         "R7 all-clockwise");

    for (int n = 0; n < 8; n++) begin
      m = 2'(n % 3);
      e = n[0];
      for (int k = 0; k < E; k++) begin
        ar[k] = rnd(-3000, 3000); ai[k] = rnd(-3000, 3000);
        br[k] = rnd(-3000, 3000); bi[k] = rnd(-3000, 3000);
      end
      ar[0] = rnd(200, 3000); ai[0] = 0; br[0] = rnd(200, 3000);
      if (bi[0] == 0) bi[0] = 123;
      send(m, e, N'(rnd(0, 4095)), N'(rnd(0, 4095)), N'(rnd(0, 4095)), ar, ai, br, bi,
           "R9 R2 burst");
    end
    idle(S + 6);
    n_chk++;
    if (tagq.size() != 0) begin
      n_fail++;
      $display("FAIL R2 outstanding results: got %0d expected 0", tagq.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule